// File: doc/BRIEF.md
# Phase-Correct PWM Timer/Counter

This block is an up/down timer/counter that makes one symmetric pulse-width-modulated waveform. A counter climbs from zero to its maximum value and then falls back to zero, so every period is a triangle. Each end value lasts for exactly one timer step. A compare value is checked against the counter on every step. When the two are equal, the waveform register is set or cleared, and the direction of the count decides which. The result is a pulse centred on the bottom of the triangle (or on the top, in the inverted mode). Its width is proportional to the compare value.

A free-running prescaler, chosen by a 3-bit clock-select field, sets the rate of the timer steps. The block can also be stopped. Software reaches the block through a synchronous write port and a combinational read port. Through these ports it sets the control fields, the compare value and the counter itself.

The compare value is double-buffered, so a period never sees a half-updated threshold. Writing the counter suppresses the compare action on the step that follows. A compare value equal to the maximum gives a constant level instead of a one-step glitch.

Top module: `pcpwm_timer`

## Requirements
- R1: After reset, the control register, counter and compare buffer all read zero, the counter direction is upward, the waveform register is low, and both `pwm_out` and `pwm_oe` are low.
- R2: Register addresses are 0 for control, 1 for the counter and 2 for the compare buffer. In control, bits [2:0] are clock select and bits [5:4] are output mode. Control bits 7, 6 and 3 read zero, and address 3 reads zero.
- R3: With steps enabled, the counter runs 0,1,…,255,254,…,1,0,1,… with a period of 510 steps. Each of 0 and 255 is held for exactly one step.
- R4: Clock select 0 stops the counter. Codes 1 to 7 give one step every 1, 8, 32, 64, 128, 256 or 1024 clocks, taken from a 10-bit prescaler that counts freely from reset.
- R5: Output mode 2 (binary 10) clears the waveform on a match while the step goes up and sets it on a match while the step goes down. The high time is 2·C clocks per 510 at divide 1, where C is the compare value.
- R6: Output mode 3 (binary 11) sets the waveform on a match while the step goes up and clears it on a match while the step goes down. The high time is 510−2·C clocks per 510 at divide 1.
- R7: Output modes 0 and 1 drive `pwm_oe` and `pwm_out` low and leave the waveform register untouched, so the waveform keeps its value when mode 2 or 3 is selected again.
- R8: When the active compare value is 255 and mode bit 5 is 1, no match happens below 255. The down-step action is applied at 255, which gives a constant high in mode 2 and a constant low in mode 3.
- R9: A compare write goes to the buffer, which reads back at once. The active compare value takes the buffer only on the step at which the counter is 255.
- R10: A counter write takes effect on the next clock edge, even if a step falls on that edge. No compare action takes place on that edge or on the next timer step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| pwm_out | output | 1 | Waveform output, low when disconnected |
| pwm_oe | output | 1 | High when the output mode drives the pin |

## Verification
Two events can fall on the same clock edge: a counter write and a timer step. With divide 1, a step occurs on every edge, so a counter write always collides with one. The bench checks that the written value is read back unchanged rather than stepped past. A second test writes the counter while the timer is stopped and then starts it on a value that would match. It checks that the waveform does not react on that first step, while a run without the write does react.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

   localparam int unsigned CS_W   = 3;
   localparam int unsigned MODE_W = 2;
   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd2;

   typedef enum logic [MODE_W-1:0] {
      OM_OFF    = 2'b00,
      OM_RSVD   = 2'b01,
      OM_NONINV = 2'b10,
      OM_INV    = 2'b11
   } out_mode_e;

   // log2 of the division ratio for each clock-select code
   function automatic int unsigned div_log2(input int unsigned code);
      case (code)
         1:       div_log2 = 0;
         2:       div_log2 = 3;
         3:       div_log2 = 5;
         4:       div_log2 = 6;
         5:       div_log2 = 7;
         6:       div_log2 = 8;
         7:       div_log2 = 10;
         default: div_log2 = 0;
      endcase
   endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
   import pcpwm_pkg::*;
#(
   parameter int unsigned PRE_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CS_W-1:0] cs,
   output logic            tick
);

   localparam int unsigned NCODES = 1 << CS_W;

   if (PRE_W < 10) begin : g_bad_pre_w
      $error("pcpwm_prescaler: PRE_W must cover the largest ratio (>= 10)");
   end

   logic [PRE_W-1:0]  pre_q;
   logic [NCODES-1:0] tick_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   assign tick_vec[0] = 1'b0;

   for (genvar g = 1; g < NCODES; g++) begin : g_div
      localparam int unsigned    SH   = div_log2(g);
      localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << SH) - 1);
      assign tick_vec[g] = ((pre_q & MASK) == MASK);
   end

   assign tick = tick_vec[cs];

endmodule

// File: rtl/pcpwm_updown.sv
module pcpwm_updown #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         step_up,
   output logic         at_top
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic up_q;

   assign at_top  = (count == TOP);
   assign step_up = up_q ? !at_top : (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         up_q  <= 1'b1;
      end else if (load) begin
         count <= load_val;
      end else if (tick) begin
         count <= step_up ? count + 1'b1 : count - 1'b1;
         up_q  <= step_up;
      end
   end

endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen
   import pcpwm_pkg::*;
#(
   parameter int unsigned W            = 8,
   parameter bit          CMP_BUFFERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cnt_wr,
   input  logic [W-1:0]      count,
   input  logic              step_up,
   input  logic              at_top,
   input  logic [MODE_W-1:0] mode,
   input  logic [W-1:0]      cmp_buf,
   output logic [W-1:0]      cmp_active,
   output logic              wave
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic blk_pend_q;
   logic suppress;
   logic hit;
   logic drive_en;
   logic set_val;

   if (CMP_BUFFERED) begin : g_buf
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      cmp_active <= '0;
         else if (tick && at_top && !cnt_wr) cmp_active <= cmp_buf;
      end
   end else begin : g_direct
      assign cmp_active = cmp_buf;
   end

   // a counter write masks its own edge and the next timer step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blk_pend_q <= 1'b0;
      else if (cnt_wr) blk_pend_q <= 1'b1;
      else if (tick)   blk_pend_q <= 1'b0;
   end

   assign suppress = cnt_wr || blk_pend_q;

   // compare value at the maximum: act only at the top of the triangle
   always_comb begin
      if (cmp_active == TOP) hit = at_top;
      else                   hit = (count == cmp_active);
   end

   assign drive_en = mode[1];
   assign set_val  = (out_mode_e'(mode) == OM_INV) ? step_up : !step_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  wave <= 1'b0;
      else if (tick && !suppress && drive_en && hit) wave <= set_val;
   end

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
   import pcpwm_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned PRE_W        = 10,
   parameter bit          CMP_BUFFERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [1:0]        rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              pwm_out,
   output logic              pwm_oe
);

   localparam int unsigned CS_LSB   = 0;
   localparam int unsigned MODE_LSB = 4;
   localparam int unsigned CTRL_W   = MODE_LSB + MODE_W;

   if (CNT_W < CTRL_W) begin : g_bad_cnt_w
      $error("pcpwm_timer: CNT_W too narrow for the control fields");
   end

   logic [CS_W-1:0]   cs_q;
   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  cmp_buf_q;
   logic [CNT_W-1:0]  cmp_active;
   logic [CNT_W-1:0]  count;
   logic              tick;
   logic              step_up;
   logic              at_top;
   logic              wave;
   logic              cnt_wr;

   assign cnt_wr = wr_en && (wr_addr == ADDR_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q      <= '0;
         mode_q    <= '0;
         cmp_buf_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_CTRL) begin
            cs_q   <= wr_data[CS_LSB +: CS_W];
            mode_q <= wr_data[MODE_LSB +: MODE_W];
         end
         if (wr_addr == ADDR_CMP) cmp_buf_q <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_CTRL: begin
            rd_data[CS_LSB +: CS_W]     = cs_q;
            rd_data[MODE_LSB +: MODE_W] = mode_q;
         end
         ADDR_CNT: rd_data = count;
         ADDR_CMP: rd_data = cmp_buf_q;
         default:  rd_data = '0;
      endcase
   end

   pcpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .cs    (cs_q),
      .tick  (tick)
   );

   pcpwm_updown #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (cnt_wr),
      .load_val (wr_data),
      .count    (count),
      .step_up  (step_up),
      .at_top   (at_top)
   );

   pcpwm_wavegen #(.W(CNT_W), .CMP_BUFFERED(CMP_BUFFERED)) u_wave (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cnt_wr     (cnt_wr),
      .count      (count),
      .step_up    (step_up),
      .at_top     (at_top),
      .mode       (mode_q),
      .cmp_buf    (cmp_buf_q),
      .cmp_active (cmp_active),
      .wave       (wave)
   );

   assign pwm_oe  = mode_q[1];
   assign pwm_out = wave & mode_q[1];

endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
   parameter int unsigned W   = 8,
   parameter bit          BUF = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         cnt_wr,
   input logic [W-1:0] wr_data,
   input logic [W-1:0] count,
   input logic [W-1:0] cmp_active,
   input logic         wave,
   input logic [1:0]   mode,
   input logic [2:0]   cs,
   input logic         pwm_out,
   input logic         pwm_oe
);

   localparam logic [W-1:0] TOPV = {W{1'b1}};

   assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs == 3'd0 && !cnt_wr) |=> $stable(count));

   assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr) |=> (count == $past(count) + 1 || count == $past(count) - 1));

   assert_write_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count == $past(wr_data)));

   assert_write_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> $stable(wave));

   assert_quiet_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[1] |=> $stable(wave));

   assert_pin_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe |-> !pwm_out);

   assert_wave_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(wave));

   assert_top_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && cmp_active == TOPV && count != TOPV) |=> $stable(wave));

   if (BUF) begin : g_buf_chk
      assert_cmp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !(tick && count == TOPV) |=> $stable(cmp_active));
   end

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.W(CNT_W), .BUF(CMP_BUFFERED)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .cnt_wr     (cnt_wr),
   .wr_data    (wr_data),
   .count      (count),
   .cmp_active (cmp_active),
   .wave       (wave),
   .mode       (mode_q),
   .cs         (cs_q),
   .pwm_out    (pwm_out),
   .pwm_oe     (pwm_oe)
);

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CNT  = 2'd1;
   localparam logic [1:0] A_CMP  = 2'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = A_CNT;
   logic [7:0] rd_data;
   logic       pwm_out;
   logic       pwm_oe;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcpwm_timer dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .pwm_out (pwm_out),
      .pwm_oe  (pwm_oe)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one write on one edge; returns at the following falling edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a;
      #1;
      v = int'(rd_data);
   endtask

   function automatic logic [7:0] ctrl(input logic [1:0] m, input logic [2:0] c);
      return {2'b00, m, 1'b0, c};
   endfunction

   task automatic t_reset_state();
      int v;
      do_reset();
      rd(A_CTRL, v); chk("R1 ctrl", v, 0);
      rd(A_CNT, v);  chk("R1 count", v, 0);
      rd(A_CMP, v);  chk("R1 cmp", v, 0);
      chk("R1 pwm_out", int'(pwm_out), 0);
      chk("R1 pwm_oe", int'(pwm_oe), 0);
   endtask

   task automatic t_regmap();
      int v;
      do_reset();
      wr(A_CTRL, 8'h35); rd(A_CTRL, v); chk("R2 ctrl readback", v, 8'h35);
      wr(A_CTRL, 8'hFF); rd(A_CTRL, v); chk("R2 ctrl unused bits", v, 8'h37);
      wr(A_CMP, 8'hA5);  rd(A_CMP, v);  chk("R2 cmp readback", v, 8'hA5);
      rd(2'd3, v); chk("R2 addr3 zero", v, 0);
      rd_addr = A_CNT;
   endtask

   task automatic t_triangle();
      int v;
      do_reset();
      rd_addr = A_CNT;
      wr(A_CTRL, ctrl(2'b00, 3'd1));
      for (int k = 1; k <= 511; k++) begin
         @(posedge clk);
         @(negedge clk);
         rd(A_CNT, v);
         if (k == 1 || k == 254 || k == 255 || k == 256 || k == 509 || k == 510 || k == 511)
            chk($sformatf("R3 count after %0d steps", k), v, (k <= 255) ? k : ((k <= 510) ? 510 - k : k - 510));
      end
   endtask

   task automatic t_prescale();
      int v;
      int div [1:7] = '{1, 8, 32, 64, 128, 256, 1024};
      do_reset();
      for (int c = 1; c <= 7; c++) begin
         wr(A_CTRL, ctrl(2'b00, 3'(c)));
         wr(A_CNT, 8'd0);
         repeat (3 * div[c]) @(posedge clk);
         @(negedge clk);
         rd(A_CNT, v);
         chk($sformatf("R4 divide code %0d", c), v, 3);
      end
      wr(A_CTRL, ctrl(2'b00, 3'd0));
      wr(A_CNT, 8'd5);
      repeat (100) @(posedge clk);
      @(negedge clk);
      rd(A_CNT, v);
      chk("R4 stopped", v, 5);
   endtask

   task automatic t_duty(input string req, input logic [1:0] m, input int k, input int exp_hi);
      int hi = 0;
      wr(A_CTRL, ctrl(m, 3'd1));
      wr(A_CMP, 8'(k));
      repeat (1100) @(posedge clk);
      for (int i = 0; i < 510; i++) begin
         @(negedge clk);
         if (pwm_out) hi++;
      end
      chk($sformatf("%s mode %0d cmp %0d high", req, m, k), hi, exp_hi);
   endtask

   task automatic t_disconnect();
      do_reset();
      wr(A_CTRL, ctrl(2'b11, 3'd1));
      @(posedge clk); @(negedge clk);
      chk("R6 up match sets", int'(pwm_out), 1);
      wr(A_CTRL, ctrl(2'b01, 3'd1));
      chk("R7 reserved oe", int'(pwm_oe), 0);
      chk("R7 reserved out", int'(pwm_out), 0);
      repeat (600) @(posedge clk);
      wr(A_CTRL, ctrl(2'b11, 3'd1));
      chk("R7 wave retained", int'(pwm_out), 1);
      wr(A_CTRL, ctrl(2'b00, 3'd1));
      chk("R7 off oe", int'(pwm_oe), 0);
   endtask

   task automatic t_buffer();
      int v;
      do_reset();
      wr(A_CTRL, ctrl(2'b10, 3'd0));
      wr(A_CMP, 8'd200);
      wr(A_CTRL, ctrl(2'b10, 3'd1));      // start edge E
      repeat (320) @(posedge clk);
      wr(A_CMP, 8'd50);                   // edge E+321, counting down
      rd(A_CMP, v); chk("R9 buffer readback", v, 50);
      repeat (278) @(posedge clk);        // through E+599
      @(negedge clk);
      chk("R9 old compare kept", int'(pwm_out), 1);
      repeat (120) @(posedge clk);        // through E+719
      @(negedge clk);
      chk("R9 clear at old value", int'(pwm_out), 0);
   endtask

   task automatic t_write_block();
      int v;
      do_reset();
      wr(A_CTRL, ctrl(2'b11, 3'd1));
      @(posedge clk); @(negedge clk);
      chk("R10 reference unblocked", int'(pwm_out), 1);
      do_reset();
      wr(A_CTRL, ctrl(2'b11, 3'd0));
      wr(A_CNT, 8'd0);
      wr(A_CTRL, ctrl(2'b11, 3'd1));
      @(posedge clk); @(negedge clk);
      chk("R10 match blocked", int'(pwm_out), 0);
      wr(A_CNT, 8'd77);
      rd(A_CNT, v);
      chk("R10 write beats step", v, 77);
   endtask

   initial begin
      t_reset_state();
      t_regmap();
      t_triangle();
      t_prescale();
      do_reset();
      t_duty("R5", 2'b10, 0, 0);
      t_duty("R5", 2'b10, 64, 128);
      t_duty("R5", 2'b10, 200, 400);
      t_duty("R8", 2'b10, 255, 510);
      t_duty("R6", 2'b11, 0, 510);
      t_duty("R6", 2'b11, 100, 310);
      t_duty("R6", 2'b11, 254, 2);
      t_duty("R8", 2'b11, 255, 0);
      t_disconnect();
      t_buffer();
      t_write_block();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule